// File: doc/BRIEF.md
# Clock Event and Alarm Detector

This block sits beside a running clock-and-calendar counter and watches the BCD value that the counter presents. On every cycle in which the counter raises its advance strobe, the block decides whether the new value marks a second tick, a selected time event or a selected calendar event. It also decides whether the value matches the alarm fields that software has enabled. Each of the four conditions sets a sticky status flag. Software clears a flag through a write-one-to-clear command.

A small register port holds the event selectors and the two alarm words. It also gives a view of the flags and holds an interrupt mask, which has separate set-only and clear-only write addresses and a read-only view. A single interrupt line is high while any flag is set and has its mask bit set.

Each flag is held by its own two-state machine. The states are FLG_IDLE and FLG_SET. Transition SET_ON_EVENT moves FLG_IDLE to FLG_SET when the flag's event is seen on a strobe. Transition CLEAR_ON_CMD moves FLG_SET to FLG_IDLE when a clear command arrives in a cycle with no event for that flag. In every other case the machine holds its state. The hours input is in 24-hour BCD, so midnight is 00 and noon is 12. The AM/PM input is used only by the alarm compare.

Top module: `tick_alarm_watch`

## Requirements
- R1: Every cycle with `adv_stb` high sets the second flag, which is status bit 2.
- R2: Bits [1:0] of the selector register (address 0) choose the time event, which is flag bit 3. Code 0 is seconds at 00. Code 1 is minutes and seconds both at 00. Code 2 is 00:00:00. Code 3 is 12:00:00. The event only counts on a strobe.
- R3: Bits [3:2] of the selector register choose the calendar event, which is flag bit 4. All codes need the time 00:00:00. Code 0 also needs weekday code 1 (Monday). Code 1 also needs date 01. Code 2 also needs date 01 and month 01. Code 3 never fires.
- R4: The time alarm word (address 1) has these fields. Seconds are at [6:0] with enable [7]. Minutes are at [14:8] with enable [15]. Hours are at [21:16], the AM/PM bit is at [22], and the hour enable is at [23]. The hour compare includes the AM/PM bit. A strobe whose value equals every enabled field sets the alarm flag, which is status bit 1.
- R5: The calendar alarm word (address 2) has a month at [20:16] with enable [23] and a date at [29:24] with enable [31]. These fields join the same all-enabled-fields-equal compare as R4.
- R6: If none of the five alarm enables is set, the alarm flag is never set.
- R7: The status register (address 3, read-only) shows the flags at bits 1 to 4 and zero elsewhere. A set flag stays set until it is cleared.
- R8: A write to address 4 clears each flag whose status bit position holds a 1. Bits written as 0 leave their flags unchanged.
- R9: When a flag's event and its clear happen in the same cycle, the flag ends set.
- R10: A 1 written to address 5 sets the matching mask bit, and a 1 written to address 6 clears it. The mask uses the same bit positions as the status register. It reads at address 7 and resets to 0.
- R11: `irq` is high exactly when some flag and its mask bit are both set.
- R12: All registers reset to 0. Addresses 0 to 2 read back only their defined bits. These are bits 3:0 for the selector, mask 0x00FFFFFF for the time alarm and mask 0xBF9F0000 for the calendar alarm. Addresses 4 to 6 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| adv_stb | input | 1 | One-cycle strobe, present value just advanced |
| now_sec | input | 7 | Current seconds, BCD |
| now_min | input | 7 | Current minutes, BCD |
| now_hour | input | 6 | Current hours, 24-hour BCD |
| now_pm | input | 1 | AM/PM indicator |
| now_wday | input | 3 | Weekday code, 1 is Monday |
| now_date | input | 6 | Day of month, BCD |
| now_month | input | 5 | Month, BCD |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| irq | output | 1 | Interrupt request |

## Verification
The properties assume that the time inputs only mean something in a cycle where `adv_stb` is high. They also assume that a register write targets a single address per cycle, so a mask set and a mask clear can never coincide. The stimulus draws only legal BCD values for every field. It biases seconds, minutes, hours, dates and months toward 00, 12 and 01 so that every selector code and alarm field actually fires. It repeats the previous time value half the time so that random alarm words can match.

// File: rtl/tae_pkg.sv
package tae_pkg;

    localparam int FLAG_N   = 4;
    localparam int FL_ALM   = 0;
    localparam int FL_SEC   = 1;
    localparam int FL_TIM   = 2;
    localparam int FL_CAL   = 3;
    localparam int STAT_LSB = 1;

    localparam int A_SEL  = 0;
    localparam int A_TALM = 1;
    localparam int A_CALM = 2;
    localparam int A_STAT = 3;
    localparam int A_CLR  = 4;
    localparam int A_IEN  = 5;
    localparam int A_IDIS = 6;
    localparam int A_MASK = 7;

    localparam logic [31:0] SEL_WMASK  = 32'h0000_000F;
    localparam logic [31:0] TALM_WMASK = 32'h00FF_FFFF;
    localparam logic [31:0] CALM_WMASK = 32'hBF9F_0000;

    typedef enum logic [1:0] {
        TEV_MINUTE   = 2'd0,
        TEV_HOUR     = 2'd1,
        TEV_MIDNIGHT = 2'd2,
        TEV_NOON     = 2'd3
    } tev_sel_e;

    typedef enum logic [1:0] {
        CEV_WEEK  = 2'd0,
        CEV_MONTH = 2'd1,
        CEV_YEAR  = 2'd2,
        CEV_NONE  = 2'd3
    } cev_sel_e;

    typedef enum logic {
        FLG_IDLE = 1'b0,
        FLG_SET  = 1'b1
    } flag_state_e;

    typedef struct packed {
        logic [6:0] sec;
        logic       sec_en;
        logic [6:0] min;
        logic       min_en;
        logic [5:0] hour;
        logic       pm;
        logic       hour_en;
        logic [4:0] month;
        logic       month_en;
        logic [5:0] date;
        logic       date_en;
    } alm_cfg_t;

endpackage

// File: rtl/tae_flag_fsm.sv
module tae_flag_fsm
    import tae_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    flag_state_e state_q;
    flag_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_IDLE: if (set_i)           state_d = FLG_SET;   // SET_ON_EVENT
            FLG_SET:  if (clr_i && !set_i) state_d = FLG_IDLE;  // CLEAR_ON_CMD
        endcase
    end

    always_comb begin
        unique case (state_q)
            FLG_IDLE: flag_o = 1'b0;
            FLG_SET:  flag_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/tae_evt_decode.sv
module tae_evt_decode
    import tae_pkg::*;
#(
    parameter logic [2:0] MONDAY_CODE = 3'd1
) (
    input  logic [6:0] sec,
    input  logic [6:0] min,
    input  logic [5:0] hour,
    input  logic [2:0] wday,
    input  logic [5:0] date,
    input  logic [4:0] month,
    input  tev_sel_e   tev_sel,
    input  cev_sel_e   cev_sel,
    output logic       tev_hit,
    output logic       cev_hit
);

    localparam logic [5:0] HOUR_NOON = 6'h12;
    localparam logic [5:0] DATE_ONE  = 6'h01;
    localparam logic [4:0] MONTH_JAN = 5'h01;

    logic sec_zero;
    logic min_zero;
    logic day_start;

    assign sec_zero  = (sec == '0);
    assign min_zero  = (min == '0);
    assign day_start = sec_zero && min_zero && (hour == '0);

    always_comb begin
        unique case (tev_sel)
            TEV_MINUTE:   tev_hit = sec_zero;
            TEV_HOUR:     tev_hit = sec_zero && min_zero;
            TEV_MIDNIGHT: tev_hit = day_start;
            TEV_NOON:     tev_hit = sec_zero && min_zero && (hour == HOUR_NOON);
        endcase
    end

    always_comb begin
        unique case (cev_sel)
            CEV_WEEK:  cev_hit = day_start && (wday == MONDAY_CODE);
            CEV_MONTH: cev_hit = day_start && (date == DATE_ONE);
            CEV_YEAR:  cev_hit = day_start && (date == DATE_ONE) && (month == MONTH_JAN);
            CEV_NONE:  cev_hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/tae_alarm_cmp.sv
module tae_alarm_cmp
    import tae_pkg::*;
(
    input  logic [6:0] sec,
    input  logic [6:0] min,
    input  logic [5:0] hour,
    input  logic       pm,
    input  logic [5:0] date,
    input  logic [4:0] month,
    input  alm_cfg_t   cfg,
    output logic       match
);

    logic any_en;
    logic sec_ok;
    logic min_ok;
    logic hour_ok;
    logic month_ok;
    logic date_ok;

    assign any_en   = cfg.sec_en | cfg.min_en | cfg.hour_en | cfg.month_en | cfg.date_en;
    assign sec_ok   = !cfg.sec_en   || (sec == cfg.sec);
    assign min_ok   = !cfg.min_en   || (min == cfg.min);
    assign hour_ok  = !cfg.hour_en  || ((hour == cfg.hour) && (pm == cfg.pm));
    assign month_ok = !cfg.month_en || (month == cfg.month);
    assign date_ok  = !cfg.date_en  || (date == cfg.date);
    assign match    = any_en && sec_ok && min_ok && hour_ok && month_ok && date_ok;

endmodule

// File: rtl/tae_regs.sv
module tae_regs
    import tae_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic [FLAG_N-1:0] flags,
    output logic [31:0]       rdata,
    output tev_sel_e          tev_sel,
    output cev_sel_e          cev_sel,
    output alm_cfg_t          alm,
    output logic [FLAG_N-1:0] clr_o,
    output logic [FLAG_N-1:0] mask_o
);

    logic [31:0]       sel_q;
    logic [31:0]       talm_q;
    logic [31:0]       calm_q;
    logic [FLAG_N-1:0] mask_q;
    logic              hit_sel, hit_talm, hit_calm, hit_clr, hit_ien, hit_idis;
    logic [FLAG_N-1:0] wbits;
    logic [FLAG_N-1:0] mset;
    logic [FLAG_N-1:0] mclr;

    assign hit_sel  = wr && (addr == ADDR_W'(A_SEL));
    assign hit_talm = wr && (addr == ADDR_W'(A_TALM));
    assign hit_calm = wr && (addr == ADDR_W'(A_CALM));
    assign hit_clr  = wr && (addr == ADDR_W'(A_CLR));
    assign hit_ien  = wr && (addr == ADDR_W'(A_IEN));
    assign hit_idis = wr && (addr == ADDR_W'(A_IDIS));

    assign wbits = wdata[STAT_LSB +: FLAG_N];
    assign clr_o = hit_clr  ? wbits : '0;
    assign mset  = hit_ien  ? wbits : '0;
    assign mclr  = hit_idis ? wbits : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q  <= '0;
            talm_q <= '0;
            calm_q <= '0;
            mask_q <= '0;
        end else begin
            if (hit_sel)  sel_q  <= wdata & SEL_WMASK;
            if (hit_talm) talm_q <= wdata & TALM_WMASK;
            if (hit_calm) calm_q <= wdata & CALM_WMASK;
            mask_q <= (mask_q | mset) & ~mclr;
        end
    end

    assign mask_o  = mask_q;
    assign tev_sel = tev_sel_e'(sel_q[1:0]);
    assign cev_sel = cev_sel_e'(sel_q[3:2]);

    assign alm.sec      = talm_q[6:0];
    assign alm.sec_en   = talm_q[7];
    assign alm.min      = talm_q[14:8];
    assign alm.min_en   = talm_q[15];
    assign alm.hour     = talm_q[21:16];
    assign alm.pm       = talm_q[22];
    assign alm.hour_en  = talm_q[23];
    assign alm.month    = calm_q[20:16];
    assign alm.month_en = calm_q[23];
    assign alm.date     = calm_q[29:24];
    assign alm.date_en  = calm_q[31];

    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_W'(A_SEL):  rdata = sel_q;
            ADDR_W'(A_TALM): rdata = talm_q;
            ADDR_W'(A_CALM): rdata = calm_q;
            ADDR_W'(A_STAT): rdata = 32'(flags) << STAT_LSB;
            ADDR_W'(A_MASK): rdata = 32'(mask_q) << STAT_LSB;
            default:         rdata = '0;
        endcase
    end

endmodule

// File: rtl/tick_alarm_watch.sv
module tick_alarm_watch
    import tae_pkg::*;
#(
    parameter int         ADDR_W      = 3,
    parameter logic [2:0] MONDAY_CODE = 3'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_stb,
    input  logic [6:0]        now_sec,
    input  logic [6:0]        now_min,
    input  logic [5:0]        now_hour,
    input  logic              now_pm,
    input  logic [2:0]        now_wday,
    input  logic [5:0]        now_date,
    input  logic [4:0]        now_month,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq
);

    tev_sel_e          tev_sel;
    cev_sel_e          cev_sel;
    alm_cfg_t          alm;
    logic [FLAG_N-1:0] clr_v;
    logic [FLAG_N-1:0] mask_q;
    logic [FLAG_N-1:0] set_v;
    logic [FLAG_N-1:0] flag_q;
    logic [4:0]        alm_en;
    logic              tev_hit;
    logic              cev_hit;
    logic              alm_hit;

    tae_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .flags   (flag_q),
        .rdata   (reg_rdata),
        .tev_sel (tev_sel),
        .cev_sel (cev_sel),
        .alm     (alm),
        .clr_o   (clr_v),
        .mask_o  (mask_q)
    );

    tae_evt_decode #(.MONDAY_CODE(MONDAY_CODE)) u_dec (
        .sec     (now_sec),
        .min     (now_min),
        .hour    (now_hour),
        .wday    (now_wday),
        .date    (now_date),
        .month   (now_month),
        .tev_sel (tev_sel),
        .cev_sel (cev_sel),
        .tev_hit (tev_hit),
        .cev_hit (cev_hit)
    );

    tae_alarm_cmp u_alm (
        .sec   (now_sec),
        .min   (now_min),
        .hour  (now_hour),
        .pm    (now_pm),
        .date  (now_date),
        .month (now_month),
        .cfg   (alm),
        .match (alm_hit)
    );

    assign alm_en = {alm.sec_en, alm.min_en, alm.hour_en, alm.month_en, alm.date_en};

    assign set_v[FL_ALM] = adv_stb && alm_hit;
    assign set_v[FL_SEC] = adv_stb;
    assign set_v[FL_TIM] = adv_stb && tev_hit;
    assign set_v[FL_CAL] = adv_stb && cev_hit;

    for (genvar g = 0; g < FLAG_N; g++) begin : g_flag
        tae_flag_fsm u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_v[g]),
            .clr_i  (clr_v[g]),
            .flag_o (flag_q[g])
        );
    end

    assign irq = |(flag_q & mask_q);

endmodule

// File: rtl/tae_chk.sv
module tae_chk
    import tae_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              adv_stb,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [FLAG_N-1:0] wflags,
    input logic              irq,
    input logic [FLAG_N-1:0] flags,
    input logic [FLAG_N-1:0] mask,
    input logic [4:0]        alm_en
);

    logic clr_cmd, ien_cmd, idis_cmd;
    assign clr_cmd  = reg_wr && (reg_addr == ADDR_W'(A_CLR));
    assign ien_cmd  = reg_wr && (reg_addr == ADDR_W'(A_IEN));
    assign idis_cmd = reg_wr && (reg_addr == ADDR_W'(A_IDIS));

    AST_SEC_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        adv_stb |=> flags[FL_SEC]); // R1

    AST_TIM_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[FL_TIM]) |-> $past(adv_stb)); // R2

    AST_CAL_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[FL_CAL]) |-> $past(adv_stb)); // R3

    AST_ALARM_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[FL_ALM]) |-> $past(alm_en != '0)); // R6

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[FL_TIM] && !(clr_cmd && wflags[FL_TIM])) |=> flags[FL_TIM]); // R7

    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_cmd && wflags[FL_CAL] && !adv_stb) |=> !flags[FL_CAL]); // R8

    AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_stb && clr_cmd && wflags[FL_SEC]) |=> flags[FL_SEC]); // R9

    AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_cmd && wflags[FL_ALM]) |=> mask[FL_ALM]); // R10

    AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (idis_cmd && wflags[FL_ALM]) |=> !mask[FL_ALM]); // R10

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((mask == '0) || (flags == '0)) |-> !irq); // R11

endmodule

bind tick_alarm_watch tae_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv_stb  (adv_stb),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .wflags   (reg_wdata[tae_pkg::STAT_LSB +: tae_pkg::FLAG_N]),
    .irq      (irq),
    .flags    (flag_q),
    .mask     (mask_q),
    .alm_en   (alm_en)
);

// File: tb/tb_tick_alarm_watch.sv
`timescale 1ns/100ps
module tb_tick_alarm_watch;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        adv_stb = 1'b0;
    logic [6:0]  now_sec = '0;
    logic [6:0]  now_min = '0;
    logic [5:0]  now_hour = '0;
    logic        now_pm = 1'b0;
    logic [2:0]  now_wday = 3'd1;
    logic [5:0]  now_date = 6'h01;
    logic [4:0]  now_month = 5'h01;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    always #2 clk = ~clk;

    tick_alarm_watch dut (
        .clk(clk), .rst_n(rst_n), .adv_stb(adv_stb),
        .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour), .now_pm(now_pm),
        .now_wday(now_wday), .now_date(now_date), .now_month(now_month),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [31:0] m_sel, m_talm, m_calm;
    logic [3:0]  m_flags, m_mask;

    logic [6:0] t_sec, t_min;
    logic [5:0] t_hour, t_date;
    logic       t_pm;
    logic [2:0] t_wday;
    logic [4:0] t_month;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic bit f_tev(input logic [1:0] s);
        bit z = (t_sec == 0) && (t_min == 0);
        case (s)
            2'd0: return t_sec == 0;
            2'd1: return z;
            2'd2: return z && (t_hour == 6'h00);
            default: return z && (t_hour == 6'h12);
        endcase
    endfunction

    function automatic bit f_cev(input logic [1:0] s);
        bit mid = (t_sec == 0) && (t_min == 0) && (t_hour == 0);
        case (s)
            2'd0: return mid && (t_wday == 3'd1);
            2'd1: return mid && (t_date == 6'h01);
            2'd2: return mid && (t_date == 6'h01) && (t_month == 5'h01);
            default: return 1'b0;
        endcase
    endfunction

    function automatic bit f_alm();
        bit se = m_talm[7], me = m_talm[15], he = m_talm[23];
        bit mo = m_calm[23], de = m_calm[31];
        if (!(se || me || he || mo || de)) return 1'b0;
        if (se && t_sec != m_talm[6:0]) return 1'b0;
        if (me && t_min != m_talm[14:8]) return 1'b0;
        if (he && (t_hour != m_talm[21:16] || t_pm != m_talm[22])) return 1'b0;
        if (mo && t_month != m_calm[20:16]) return 1'b0;
        if (de && t_date != m_calm[29:24]) return 1'b0;
        return 1'b1;
    endfunction

    task automatic cycle(input string tag, input bit stb, input bit wr,
                         input logic [2:0] a, input logic [31:0] d);
        logic [3:0] setv, clrv, wb;
        @(negedge clk);
        adv_stb = stb; reg_wr = wr; reg_addr = a; reg_wdata = d;
        now_sec = t_sec; now_min = t_min; now_hour = t_hour; now_pm = t_pm;
        now_wday = t_wday; now_date = t_date; now_month = t_month;
        @(posedge clk);
        wb = d[4:1];
        setv = '0;
        if (stb) setv = {f_cev(m_sel[3:2]), f_tev(m_sel[1:0]), 1'b1, f_alm()};
        clrv = (wr && a == 3'd4) ? wb : 4'b0;
        m_flags = (m_flags & ~clrv) | setv;
        if (wr) begin
            case (a)
                3'd0: m_sel  = d & 32'h0000_000F;
                3'd1: m_talm = d & 32'h00FF_FFFF;
                3'd2: m_calm = d & 32'hBF9F_0000;
                3'd5: m_mask = m_mask | wb;
                3'd6: m_mask = m_mask & ~wb;
                default: ;
            endcase
        end
        #0.5;
        adv_stb = 1'b0; reg_wr = 1'b0; reg_addr = 3'd3;
        #0.5;
        chk(tag, reg_rdata, {27'b0, m_flags, 1'b0});
        chk("R11", {31'b0, irq}, {31'b0, |(m_flags & m_mask)});
        reg_addr = 3'd7;
        #0.5;
        chk("R10", reg_rdata, {27'b0, m_mask, 1'b0});
    endtask

    task automatic rd(input string tag, input logic [2:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #0.5;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic set_t(input logic [6:0] s, input logic [6:0] m, input logic [5:0] h,
                         input bit p, input logic [2:0] w, input logic [5:0] dt,
                         input logic [4:0] mo);
        t_sec = s; t_min = m; t_hour = h; t_pm = p; t_wday = w; t_date = dt; t_month = mo;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        m_sel = '0; m_talm = '0; m_calm = '0; m_flags = '0; m_mask = '0;
        set_t(7'h05, 7'h10, 6'h03, 1'b0, 3'd2, 6'h09, 5'h04);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state R12, R7, R10, R11
        rd("R12", 3'd0, 32'h0);
        rd("R12", 3'd1, 32'h0);
        rd("R12", 3'd2, 32'h0);
        rd("R7", 3'd3, 32'h0);
        rd("R10", 3'd7, 32'h0);
        chk("R11", {31'b0, irq}, 32'h0);

        // register readback masks R12
        cycle("R12", 1'b0, 1'b1, 3'd0, 32'hFFFF_FFFF);
        rd("R12", 3'd0, 32'h0000_000F);
        cycle("R12", 1'b0, 1'b1, 3'd1, 32'hFFFF_FFFF);
        rd("R12", 3'd1, 32'h00FF_FFFF);
        cycle("R12", 1'b0, 1'b1, 3'd2, 32'hFFFF_FFFF);
        rd("R12", 3'd2, 32'hBF9F_0000);
        cycle("R12", 1'b0, 1'b1, 3'd4, 32'hFFFF_FFFF);
        rd("R12", 3'd4, 32'h0);
        cycle("R12", 1'b0, 1'b1, 3'd1, 32'h0);
        cycle("R12", 1'b0, 1'b1, 3'd2, 32'h0);

        // R6: no enable, time equal to disabled alarm fields
        cycle("R6", 1'b0, 1'b1, 3'd1, 32'h0000_0000);
        set_t(7'h00, 7'h00, 6'h00, 1'b0, 3'd3, 6'h05, 5'h05);
        cycle("R6", 1'b1, 1'b0, 3'd0, 32'h0);

        // R1 second flag, R8 clear of all, R8 write of zero
        cycle("R8", 1'b0, 1'b1, 3'd4, 32'h0000_001E);
        set_t(7'h27, 7'h41, 6'h09, 1'b0, 3'd3, 6'h05, 5'h05);
        cycle("R1", 1'b1, 1'b0, 3'd0, 32'h0);
        cycle("R8", 1'b0, 1'b1, 3'd4, 32'h0000_0000);
        // R9 event and clear together
        cycle("R9", 1'b1, 1'b1, 3'd4, 32'h0000_0004);

        // R2 noon, R3 year (selector 0xB)
        cycle("R2", 1'b0, 1'b1, 3'd0, 32'h0000_000B);
        set_t(7'h00, 7'h00, 6'h12, 1'b1, 3'd4, 6'h10, 5'h06);
        cycle("R2", 1'b1, 1'b0, 3'd0, 32'h0);
        set_t(7'h00, 7'h00, 6'h00, 1'b0, 3'd4, 6'h01, 5'h01);
        cycle("R3", 1'b1, 1'b0, 3'd0, 32'h0);
        cycle("R8", 1'b0, 1'b1, 3'd4, 32'h0000_001E);
        cycle("R3", 1'b0, 1'b1, 3'd0, 32'h0000_000E);
        cycle("R3", 1'b1, 1'b0, 3'd0, 32'h0);

        // R4 time alarm with AM/PM
        cycle("R4", 1'b0, 1'b1, 3'd1, 32'h00C8_9530);
        set_t(7'h30, 7'h15, 6'h08, 1'b0, 3'd5, 6'h11, 5'h03);
        cycle("R4", 1'b1, 1'b0, 3'd0, 32'h0);
        set_t(7'h30, 7'h15, 6'h08, 1'b1, 3'd5, 6'h11, 5'h03);
        cycle("R4", 1'b1, 1'b0, 3'd0, 32'h0);

        // R5 calendar alarm
        cycle("R5", 1'b0, 1'b1, 3'd1, 32'h0);
        cycle("R5", 1'b0, 1'b1, 3'd4, 32'h0000_001E);
        cycle("R5", 1'b0, 1'b1, 3'd2, 32'h9487_0000);
        set_t(7'h44, 7'h02, 6'h17, 1'b1, 3'd6, 6'h15, 5'h07);
        cycle("R5", 1'b1, 1'b0, 3'd0, 32'h0);
        set_t(7'h44, 7'h02, 6'h17, 1'b1, 3'd6, 6'h14, 5'h07);
        cycle("R5", 1'b1, 1'b0, 3'd0, 32'h0);

        // R10 / R11 mask set and clear
        cycle("R10", 1'b0, 1'b1, 3'd5, 32'h0000_0002);
        cycle("R11", 1'b0, 1'b1, 3'd6, 32'h0000_0002);

        // random phase
        for (int i = 0; i < 3000; i++) begin
            bit stb, wr;
            logic [2:0] a;
            logic [31:0] d;
            if ($urandom % 2 == 0) begin
                t_sec   = ($urandom % 3 == 0) ? 7'h00 : 7'(bcd($urandom % 60));
                t_min   = ($urandom % 3 == 0) ? 7'h00 : 7'(bcd($urandom % 60));
                case ($urandom % 3)
                    0: t_hour = 6'h00;
                    1: t_hour = 6'h12;
                    default: t_hour = 6'(bcd($urandom % 24));
                endcase
                t_pm    = 1'($urandom);
                t_wday  = 3'(1 + $urandom % 7);
                t_date  = ($urandom % 3 == 0) ? 6'h01 : 6'(bcd(1 + $urandom % 31));
                t_month = ($urandom % 3 == 0) ? 5'h01 : 5'(bcd(1 + $urandom % 12));
            end
            stb = ($urandom % 10) < 7;
            wr  = ($urandom % 4) == 0;
            a   = 3'($urandom);
            d   = $urandom;
            if (a == 3'd1 && d[0]) d = {8'b0, d[9], t_pm, t_hour, d[8], t_min, d[10], t_sec};
            if (a == 3'd2 && d[0]) d = {d[9], 1'b0, t_date, d[8], 2'b0, t_month, 16'b0};
            cycle("R7", stb, wr, a, d);
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule